// File: doc/BRIEF.md
# Clear-on-Read Test Error Counter Bank

This block keeps three error tallies for the receive side of a transceiver test-pattern checker. A checker elsewhere raises a one-cycle pulse for every received character it finds in error. There is one pulse input for the fixed high/mixed/low frequency patterns, one for the PRBS7 pattern and one for the CRPAT pattern. The block counts those pulses. Software reads the counts through a small register port made of a read strobe, a 5-bit address and 16-bit read data.

Every count clears when it is read, and every count stops at its all-ones value instead of wrapping. The CRPAT count is 32 bits wide and is read as two 16-bit halves. The upper half must be read first. That read hands back bits 31:16, copies bits 15:0 into a holding register and clears the whole 32-bit count in the same cycle. The later lower-half read returns the held copy.

A two-state machine tracks the holding register. It starts in `SNAP_HELD`, because the holding register leaves reset with a value in it. An upper-half read (transition `T_CAPTURE`) moves it to `SNAP_HELD` from either state. A lower-half read (transition `T_DRAIN`) moves it to `SNAP_EMPTY` from either state. In `SNAP_EMPTY` a lower-half read returns zero.

Read data is combinational. It is valid in the same cycle as the strobe, and the clearing takes effect at the clock edge that ends that cycle.

Top module: `test_err_counter_bank`

## Requirements
- R1: After reset, a read returns 0xFFFD at addresses 0x16, 0x18 and 0x1D, and 0xFFFF at address 0x17.
- R2: The fixed-pattern count at 0x16 rises by one per `fixed_err_i` pulse and holds at 0xFFFF.
- R3: A read of 0x16 returns the count in that same cycle and clears it. If a pulse arrives in the cycle of the read, the count restarts at 1.
- R4: The PRBS7 count at 0x1D rises by one per `prbs_err_i` pulse and holds at 0xFFFF. A read returns the count and clears it (to 1 if a pulse arrives in the same cycle), and counting then resumes.
- R5: The CRPAT count is 32 bits wide. It rises by one per `crpat_err_i` pulse, carries from bit 15 into bit 16, and holds at 0xFFFF_FFFF.
- R6: A read of 0x17 returns CRPAT bits 31:16. At the same edge it copies bits 15:0 into the holding register and clears the 32-bit count (to 1 if a pulse arrives in the same cycle).
- R7: A read of 0x18 returns the holding register and then empties it. A second read of 0x18 with no read of 0x17 in between returns 0. A read of 0x18 never changes the 32-bit count.
- R8: With `rd_en_i` low, or at any address other than 0x16, 0x17, 0x18 and 0x1D, `rd_data_o` is 0 and no count or held value changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fixed_err_i | input | 1 | One-cycle pulse per errored character, fixed patterns |
| prbs_err_i | input | 1 | One-cycle pulse per errored character, PRBS7 |
| crpat_err_i | input | 1 | One-cycle pulse per errored character, CRPAT |
| rd_en_i | input | 1 | Read strobe; a read clears the addressed count at the next edge |
| rd_addr_i | input | 5 | Register address |
| rd_data_o | output | 16 | Read data, valid in the strobe cycle |

## Verification
The bench drives an error pulse in the same cycle as a clearing read. A design that dropped that pulse would restart at 0, and one that counted it before the read would return a value one too high. It runs the counters past all-ones to catch any design that wraps to zero. It also drives 65537 CRPAT pulses to prove the carry from bit 15 into bit 16, which a design that split the count into two unlinked halves would lose.

The bench reads the lower half twice, reads it again after fresh CRPAT errors, and reads unmapped addresses. A snapshot that was not emptied, or a lower-half read that disturbed the live count, would show up in the next upper/lower pair.

// File: rtl/tec_pkg.sv
package tec_pkg;
    localparam int ADDR_W   = 5;
    localparam int DATA_W   = 16;
    localparam int LONG_W   = 2 * DATA_W;

    localparam logic [ADDR_W-1:0] A_FIXED   = 5'h16;
    localparam logic [ADDR_W-1:0] A_CRPAT_H = 5'h17;
    localparam logic [ADDR_W-1:0] A_CRPAT_L = 5'h18;
    localparam logic [ADDR_W-1:0] A_PRBS    = 5'h1D;

    localparam logic [DATA_W-1:0] RST_SHORT = 16'hFFFD;
    localparam logic [LONG_W-1:0] RST_LONG  = 32'hFFFF_FFFD;

    typedef enum logic {
        SNAP_EMPTY = 1'b0,
        SNAP_HELD  = 1'b1
    } snap_state_e;
endpackage

// File: rtl/tec_sat_counter.sv
module tec_sat_counter #(
    parameter int          WIDTH   = 16,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] count_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

    logic [WIDTH-1:0] count_d;

    always_comb begin
        if (clr_i) begin
            count_d = inc_i ? ONE : '0;
        end else if (inc_i && (count_o != ALL_ONES)) begin
            count_d = count_o + ONE;
        end else begin
            count_d = count_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= RST_VAL;
        end else begin
            count_o <= count_d;
        end
    end
endmodule

// File: rtl/tec_split_snap.sv
module tec_split_snap
    import tec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              drain_i,
    input  logic [DATA_W-1:0] low_i,
    output logic [DATA_W-1:0] lo_data_o,
    output snap_state_e       state_o,
    output logic [DATA_W-1:0] hold_o
);
    snap_state_e state_q, state_d;

    // next-state logic: T_CAPTURE and T_DRAIN
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SNAP_EMPTY: if (capture_i) state_d = SNAP_HELD;
            SNAP_HELD:  if (drain_i)   state_d = SNAP_EMPTY;
                        else if (capture_i) state_d = SNAP_HELD;
            default:    state_d = SNAP_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SNAP_HELD;
        end else begin
            state_q <= state_d;
        end
    end

    // holding register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_o <= RST_SHORT;
        end else if (capture_i) begin
            hold_o <= low_i;
        end else if (drain_i) begin
            hold_o <= '0;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            SNAP_HELD:  lo_data_o = hold_o;
            SNAP_EMPTY: lo_data_o = '0;
            default:    lo_data_o = '0;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/test_err_counter_bank.sv
module test_err_counter_bank
    import tec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fixed_err_i,
    input  logic              prbs_err_i,
    input  logic              crpat_err_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic              rd_fixed, rd_prbs, rd_hi, rd_lo;
    logic [DATA_W-1:0] fixed_cnt, prbs_cnt, lo_data, hold_val;
    logic [LONG_W-1:0] crpat_cnt;
    snap_state_e       snap_state;

    assign rd_fixed = rd_en_i && (rd_addr_i == A_FIXED);
    assign rd_prbs  = rd_en_i && (rd_addr_i == A_PRBS);
    assign rd_hi    = rd_en_i && (rd_addr_i == A_CRPAT_H);
    assign rd_lo    = rd_en_i && (rd_addr_i == A_CRPAT_L);

    tec_sat_counter #(.WIDTH(DATA_W), .RST_VAL(RST_SHORT)) u_fixed (
        .clk(clk), .rst_n(rst_n), .inc_i(fixed_err_i), .clr_i(rd_fixed),
        .count_o(fixed_cnt)
    );

    tec_sat_counter #(.WIDTH(DATA_W), .RST_VAL(RST_SHORT)) u_prbs (
        .clk(clk), .rst_n(rst_n), .inc_i(prbs_err_i), .clr_i(rd_prbs),
        .count_o(prbs_cnt)
    );

    tec_sat_counter #(.WIDTH(LONG_W), .RST_VAL(RST_LONG)) u_crpat (
        .clk(clk), .rst_n(rst_n), .inc_i(crpat_err_i), .clr_i(rd_hi),
        .count_o(crpat_cnt)
    );

    tec_split_snap u_snap (
        .clk(clk), .rst_n(rst_n), .capture_i(rd_hi), .drain_i(rd_lo),
        .low_i(crpat_cnt[DATA_W-1:0]), .lo_data_o(lo_data),
        .state_o(snap_state), .hold_o(hold_val)
    );

    always_comb begin
        rd_data_o = '0;
        if (rd_en_i) begin
            unique case (rd_addr_i)
                A_FIXED:   rd_data_o = fixed_cnt;
                A_PRBS:    rd_data_o = prbs_cnt;
                A_CRPAT_H: rd_data_o = crpat_cnt[LONG_W-1:DATA_W];
                A_CRPAT_L: rd_data_o = lo_data;
                default:   rd_data_o = '0;
            endcase
        end
    end
endmodule

// File: rtl/tec_checks.sv
module tec_checks
    import tec_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              fixed_err_i,
    input logic              prbs_err_i,
    input logic              crpat_err_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic [DATA_W-1:0] fixed_cnt,
    input logic [DATA_W-1:0] prbs_cnt,
    input logic [LONG_W-1:0] crpat_cnt,
    input logic [DATA_W-1:0] hold_val,
    input snap_state_e       snap_state
);
    logic known_addr;
    assign known_addr = (rd_addr_i == A_FIXED) || (rd_addr_i == A_PRBS) ||
                        (rd_addr_i == A_CRPAT_H) || (rd_addr_i == A_CRPAT_L);

    p_fixed_sat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fixed_cnt == 16'hFFFF) && !(rd_en_i && rd_addr_i == A_FIXED)
        |=> fixed_cnt == 16'hFFFF);

    p_fixed_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i && (rd_addr_i == A_FIXED)
        |=> fixed_cnt == {15'd0, $past(fixed_err_i)});

    p_prbs_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i && (rd_addr_i == A_PRBS)
        |=> prbs_cnt == {15'd0, $past(prbs_err_i)});

    p_crpat_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (crpat_cnt == 32'hFFFF_FFFF) && !(rd_en_i && rd_addr_i == A_CRPAT_H)
        |=> crpat_cnt == 32'hFFFF_FFFF);

    p_hold_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i && (rd_addr_i == A_CRPAT_H)
        |=> (hold_val == $past(crpat_cnt[DATA_W-1:0])) &&
            (crpat_cnt == {31'd0, $past(crpat_err_i)}));

    p_snap_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_state == SNAP_EMPTY) |-> hold_val == '0);

    p_lo_keeps_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i && (rd_addr_i == A_CRPAT_L) && !crpat_err_i
        |=> $stable(crpat_cnt));

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_i && known_addr) |-> rd_data_o == '0);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_i && known_addr) |=> $stable(hold_val));
endmodule

bind test_err_counter_bank tec_checks u_checks (
    .clk(clk), .rst_n(rst_n), .fixed_err_i(fixed_err_i), .prbs_err_i(prbs_err_i),
    .crpat_err_i(crpat_err_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .fixed_cnt(fixed_cnt), .prbs_cnt(prbs_cnt),
    .crpat_cnt(crpat_cnt), .hold_val(hold_val), .snap_state(snap_state)
);

// File: tb/test_err_counter_bank_tb.sv
module test_err_counter_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fixed_err = 1'b0, prbs_err = 1'b0, crpat_err = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  rd_addr = 5'h0;
    logic [15:0] rd_data;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    test_err_counter_bank dut_i (
        .clk(clk), .rst_n(rst_n), .fixed_err_i(fixed_err), .prbs_err_i(prbs_err),
        .crpat_err_i(crpat_err), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data)
    );

    // {rd, addr[4:0], fixed, prbs, crpat, expected[15:0]}
    localparam logic [24:0] VEC [16] = '{
        {1'b1, 5'h1D, 3'b010, 16'hFFFD},  // R1 R4: reset value, pulse during read
        {1'b1, 5'h1D, 3'b000, 16'h0001},  // R4: restarted at 1
        {1'b1, 5'h17, 3'b000, 16'hFFFF},  // R1 R6
        {1'b1, 5'h18, 3'b000, 16'hFFFD},  // R1 R7
        {1'b1, 5'h18, 3'b000, 16'h0000},  // R7: drained
        {1'b1, 5'h16, 3'b100, 16'hFFFD},  // R1 R3: pulse during read
        {1'b0, 5'h16, 3'b100, 16'h0000},  // R8: strobe low
        {1'b1, 5'h00, 3'b100, 16'h0000},  // R8: unmapped
        {1'b1, 5'h15, 3'b000, 16'h0000},  // R8: unmapped
        {1'b1, 5'h16, 3'b000, 16'h0003},  // R2 R3
        {1'b0, 5'h00, 3'b001, 16'h0000},
        {1'b0, 5'h00, 3'b001, 16'h0000},
        {1'b0, 5'h00, 3'b001, 16'h0000},
        {1'b1, 5'h17, 3'b000, 16'h0000},  // R6
        {1'b1, 5'h18, 3'b000, 16'h0003},  // R6 R7
        {1'b1, 5'h16, 3'b000, 16'h0000}   // R3
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rd_data=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one cycle at negedge, sample 1 ns before the next posedge
    task automatic step(input logic rd, input logic [4:0] addr, input logic f,
                        input logic p, input logic c);
        @(negedge clk);
        rd_en = rd; rd_addr = addr; fixed_err = f; prbs_err = p; crpat_err = c;
        #4;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rd_en = 1'b0; fixed_err = 1'b0; prbs_err = 1'b0; crpat_err = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 5'h16, 0, 0, 0);
        check("R1 idle output", rd_data, 16'h0000);

        for (int i = 0; i < 16; i++) begin
            step(VEC[i][24], VEC[i][23:19], VEC[i][18], VEC[i][17], VEC[i][16]);
            check($sformatf("vector %0d", i), rd_data, VEC[i][15:0]);
        end

        // R2 / R4 saturation from reset value 0xFFFD
        do_reset();
        for (int i = 0; i < 5; i++) step(0, 5'h0, 1, 1, 1);
        step(1, 5'h16, 0, 0, 0);
        check("R2 fixed saturation", rd_data, 16'hFFFF);
        step(1, 5'h1D, 0, 0, 0);
        check("R4 prbs saturation", rd_data, 16'hFFFF);
        step(0, 5'h0, 0, 1, 0);
        step(0, 5'h0, 0, 1, 0);
        step(1, 5'h1D, 0, 0, 0);
        check("R4 prbs resumes after read", rd_data, 16'h0002);
        // R5 32-bit saturation
        step(1, 5'h17, 0, 0, 0);
        check("R5 crpat sat high", rd_data, 16'hFFFF);
        step(1, 5'h18, 0, 0, 0);
        check("R5 crpat sat low", rd_data, 16'hFFFF);

        // R5 carry from bit 15 into bit 16
        for (int i = 0; i < 65537; i++) step(0, 5'h0, 0, 0, 1);
        step(1, 5'h17, 0, 0, 1);  // R6: pulse during upper read -> restart at 1
        check("R5 carry high half", rd_data, 16'h0001);
        step(1, 5'h18, 0, 0, 0);
        check("R5 carry low half", rd_data, 16'h0001);
        step(1, 5'h17, 0, 0, 0);
        check("R6 restart at 1 high", rd_data, 16'h0000);
        step(1, 5'h18, 0, 0, 1);  // R7: low read does not clear the live count
        check("R6 restart at 1 low", rd_data, 16'h0001);
        step(0, 5'h0, 0, 0, 1);
        step(1, 5'h18, 0, 0, 0);
        check("R7 low read without upper", rd_data, 16'h0000);
        step(1, 5'h1F, 0, 0, 0);
        check("R8 unmapped 0x1F", rd_data, 16'h0000);
        step(1, 5'h17, 0, 0, 0);
        check("R7 count kept across low reads high", rd_data, 16'h0000);
        step(1, 5'h18, 0, 0, 0);
        check("R7 count kept across low reads low", rd_data, 16'h0002);

        // R1 after a second reset
        do_reset();
        step(1, 5'h17, 0, 0, 0);
        check("R1 reset high half", rd_data, 16'hFFFF);
        step(1, 5'h16, 0, 0, 0);
        check("R1 reset fixed", rd_data, 16'hFFFD);

        step(0, 5'h0, 0, 0, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule